// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencing Controller

This controller decides when a shadowed SRAM is copied into its nonvolatile twin (a store) and when the twin is copied back (a recall). Four events can start an operation:

- a falling edge on the external hardware store request, which is the level read back from an open-drain busy pin;
- loss of supply, reported on a digital supply-good input;
- single-cycle software command pulses, for store, recall, automatic-store off and automatic-store on;
- the return of supply after reset or after an outage.

The controller keeps a dirty flag that records whether any SRAM write has completed since the last store or recall. Hardware-requested stores and supply-loss stores depend on that flag. Software stores do not.

The controller gates the SRAM read and write enables. While a store runs it pulls the busy pin low. The store, power-up recall, software recall and grace-window durations are all parameterised cycle counts. When a hardware request arrives, a grace window keeps reads and an already-running write enabled, so that traffic in flight can finish before the array is locked. Writes that start after the request falls are refused until the request is released.

The state machine has six states:

- `S_OFF`: supply low or not yet recalled.
- `S_PU_RECALL`: power-up recall.
- `S_IDLE`: normal access.
- `S_GRACE`: hardware-request grace window.
- `S_STORE`: store running.
- `S_SW_RECALL`: software recall.

The named transitions are:

- OFF→PU_RECALL when supply is good.
- PU_RECALL, STORE and SW_RECALL each leave when their duration expires. They go to IDLE if supply is good and to OFF if it is not.
- IDLE→STORE on supply loss (dirty and automatic store enabled).
- IDLE→OFF on supply loss otherwise.
- IDLE→GRACE on a hardware request edge.
- IDLE→STORE on a software store.
- IDLE→SW_RECALL on a software recall.
- GRACE→STORE when the window expires with the flag dirty.
- GRACE→IDLE when the window expires clean.
- GRACE on supply loss behaves like IDLE.

In IDLE the triggers are taken in this priority: supply loss, then hardware edge, then software store, then software recall.

Top module: `nvs_seq_ctrl`

## Requirements
- R1: After reset the controller is in S_OFF: `hsb_pull_low`, `array_recall` and all access enables are 0. No recall starts until `pwr_ok` is 1. Once `pwr_ok` is 1, a recall runs with `array_recall`=1 for exactly PU_RECALL_CYC cycles, and then the controller enters S_IDLE.
- R2: In S_IDLE or S_GRACE with `pwr_ok`=1, `rd_en` follows `rd_req` in the same cycle and `wr_en` follows `wr_req` in the same cycle (subject to R5). In every other case both enables are 0.
- R3: A falling edge of `hw_req_n` while the dirty flag is clear opens the grace window, which then closes without any store (`hsb_pull_low` stays 0).
- R4: A falling edge of `hw_req_n` while the dirty flag is set leads to exactly GRACE_CYC cycles of grace, followed by a store. During the store `hsb_pull_low`=1 for exactly STORE_CYC cycles and no access is enabled.
- R5: While `hw_req_n`=0, a write is enabled only if `wr_en` was 1 in the previous cycle, so a write already in progress continues. A newly requested write is refused until `hw_req_n` returns to 1. Reads stay enabled during the grace window.
- R6: A `sw_store` pulse in S_IDLE starts a STORE_CYC-cycle store even when the dirty flag is clear.
- R7: A `sw_recall` pulse in S_IDLE starts a recall with `array_recall`=1 for exactly SW_RECALL_CYC cycles, with reads and writes disabled.
- R8: When `pwr_ok` falls in S_IDLE or S_GRACE, with the dirty flag set and automatic store enabled, a STORE_CYC-cycle store runs. No recall starts while `pwr_ok` stays 0. When `pwr_ok` returns to 1, a power-up recall follows.
- R9: Automatic store is enabled at reset. A `auto_off` pulse disables it, so that a supply loss with the dirty flag set goes straight to S_OFF with no store. A `auto_on` pulse enables it again.
- R10: Any trigger that arrives while a store or recall is running is ignored. In particular, a `hw_req_n` fall during a store starts no later operation.
- R11: `store_done` and `recall_done` are each 1 for exactly one cycle: the last cycle of every store and every recall, respectively.
- R12: The dirty flag is set by any cycle with `wr_en`=1 and cleared when a store or recall completes. After a completed recall, a hardware request therefore produces no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply above the switch threshold (synchronised upstream) |
| hw_req_n | input | 1 | Level read back from the busy pin; 0 requests a store |
| hsb_pull_low | output | 1 | 1 enables the open-drain pull-down of the busy pin |
| sw_store | input | 1 | Software store command pulse |
| sw_recall | input | 1 | Software recall command pulse |
| auto_off | input | 1 | Software pulse disabling automatic store on supply loss |
| auto_on | input | 1 | Software pulse enabling automatic store on supply loss |
| rd_req | input | 1 | SRAM read request |
| wr_req | input | 1 | SRAM write request |
| rd_en | output | 1 | Gated SRAM read enable |
| wr_en | output | 1 | Gated SRAM write enable |
| array_store | output | 1 | Store command to the storage array |
| array_recall | output | 1 | Recall command to the storage array |
| store_done | output | 1 | One-cycle pulse on the last store cycle |
| recall_done | output | 1 | One-cycle pulse on the last recall cycle |

## Verification
The bench builds the controller with the following durations:

| Parameter | Cycles |
|---|---|
| STORE_CYC | 12 |
| PU_RECALL_CYC | 16 |
| SW_RECALL_CYC | 6 |
| GRACE_CYC | 4 |

In place of millisecond-scale counts, these short durations let every store and recall be measured to the exact cycle. They also let the grace window be probed cycle by cycle, with a continuing write, a read and a refused new write. The small counts make room for many operations back to back, including two outages, toggling automatic store off and on, and a hardware request that falls during a software store.

// File: rtl/nvs_seq_pkg.sv
package nvs_seq_pkg;

    typedef enum logic [2:0] {
        S_OFF       = 3'd0,
        S_PU_RECALL = 3'd1,
        S_IDLE      = 3'd2,
        S_GRACE     = 3'd3,
        S_STORE     = 3'd4,
        S_SW_RECALL = 3'd5
    } nvs_state_e;

    function automatic int nvs_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/nvs_trig_cond.sv
// Conditions the hardware request into a falling-edge event and holds the
// automatic-store enable that the software pulses toggle.
module nvs_trig_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_req_n,
    input  logic auto_off,
    input  logic auto_on,
    output logic hw_fall,
    output logic auto_en
);

    logic hw_req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_req_q <= 1'b1;
            auto_en  <= 1'b1;
        end else begin
            hw_req_q <= hw_req_n;
            if (auto_off)
                auto_en <= 1'b0;
            else if (auto_on)
                auto_en <= 1'b1;
        end
    end

    assign hw_fall = hw_req_q && !hw_req_n;

endmodule

// File: rtl/nvs_access_gate.sv
// Gates SRAM enables and keeps the dirty flag.
module nvs_access_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic access_ok,
    input  logic hw_req_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic clr_dirty,
    output logic rd_en,
    output logic wr_en,
    output logic dirty_now
);

    logic wr_cont;   // a write was enabled last cycle
    logic dirty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cont <= 1'b0;
            dirty_q <= 1'b0;
        end else begin
            wr_cont <= wr_en;
            if (clr_dirty)
                dirty_q <= 1'b0;
            else if (wr_en)
                dirty_q <= 1'b1;
        end
    end

    always_comb begin
        rd_en = rd_req && access_ok;
        // once the request is low only a continuing write may proceed
        wr_en = wr_req && access_ok && (hw_req_n || wr_cont);
    end

    // include a write landing in the very cycle a decision is taken
    assign dirty_now = dirty_q || wr_en;

endmodule

// File: rtl/nvs_dur_timer.sv
// Counts cycles spent in a timed state; flags the final cycle.
module nvs_dur_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [CW-1:0] last,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || !run)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == last);

endmodule

// File: rtl/nvs_seq_ctrl.sv
module nvs_seq_ctrl #(
    parameter int STORE_CYC     = 2500000,
    parameter int PU_RECALL_CYC = 4000000,
    parameter int SW_RECALL_CYC = 10000,
    parameter int GRACE_CYC     = 14000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic hw_req_n,
    output logic hsb_pull_low,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic auto_off,
    input  logic auto_on,
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_en,
    output logic wr_en,
    output logic array_store,
    output logic array_recall,
    output logic store_done,
    output logic recall_done
);
    import nvs_seq_pkg::*;

    localparam int MAXC = nvs_max4(STORE_CYC, PU_RECALL_CYC, SW_RECALL_CYC, GRACE_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LAST_STORE = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] LAST_PU    = CW'(PU_RECALL_CYC - 1);
    localparam logic [CW-1:0] LAST_SW    = CW'(SW_RECALL_CYC - 1);
    localparam logic [CW-1:0] LAST_GRACE = CW'(GRACE_CYC - 1);

    nvs_state_e    state_q, state_d;
    logic          hw_fall, auto_en, dirty_now, expired;
    logic          access_ok, timed, clr_dirty;
    logic [CW-1:0] last_sel;

    nvs_trig_cond u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_req_n (hw_req_n),
        .auto_off (auto_off),
        .auto_on  (auto_on),
        .hw_fall  (hw_fall),
        .auto_en  (auto_en)
    );

    nvs_access_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .access_ok (access_ok),
        .hw_req_n  (hw_req_n),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .clr_dirty (clr_dirty),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .dirty_now (dirty_now)
    );

    nvs_dur_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timed),
        .restart (state_d != state_q),
        .last    (last_sel),
        .expired (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_OFF;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (pwr_ok) state_d = S_PU_RECALL;
            end
            S_PU_RECALL, S_STORE, S_SW_RECALL: begin
                if (expired) state_d = pwr_ok ? S_IDLE : S_OFF;
            end
            S_IDLE: begin
                if (!pwr_ok)
                    state_d = (dirty_now && auto_en) ? S_STORE : S_OFF;
                else if (hw_fall)
                    state_d = S_GRACE;
                else if (sw_store)
                    state_d = S_STORE;
                else if (sw_recall)
                    state_d = S_SW_RECALL;
            end
            S_GRACE: begin
                if (!pwr_ok)
                    state_d = (dirty_now && auto_en) ? S_STORE : S_OFF;
                else if (expired)
                    state_d = dirty_now ? S_STORE : S_IDLE;
            end
            default: state_d = S_OFF;
        endcase
    end

    // outputs
    always_comb begin
        access_ok    = 1'b0;
        timed        = 1'b0;
        last_sel     = LAST_STORE;
        hsb_pull_low = 1'b0;
        array_store  = 1'b0;
        array_recall = 1'b0;
        store_done   = 1'b0;
        recall_done  = 1'b0;
        unique case (state_q)
            S_OFF: ;
            S_PU_RECALL: begin
                timed        = 1'b1;
                last_sel     = LAST_PU;
                array_recall = 1'b1;
                recall_done  = expired;
            end
            S_IDLE: begin
                access_ok = pwr_ok;
            end
            S_GRACE: begin
                access_ok = pwr_ok;
                timed     = 1'b1;
                last_sel  = LAST_GRACE;
            end
            S_STORE: begin
                timed        = 1'b1;
                last_sel     = LAST_STORE;
                hsb_pull_low = 1'b1;
                array_store  = 1'b1;
                store_done   = expired;
            end
            S_SW_RECALL: begin
                timed        = 1'b1;
                last_sel     = LAST_SW;
                array_recall = 1'b1;
                recall_done  = expired;
            end
            default: ;
        endcase
        clr_dirty = store_done || recall_done;
    end

endmodule

// File: rtl/nvs_seq_ctrl_chk.sv
module nvs_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok,
    input logic hw_req_n,
    input logic hsb_pull_low,
    input logic rd_en,
    input logic wr_en,
    input logic array_recall,
    input logic store_done,
    input logic recall_done
);

    AST_SUPPLY_GATES_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (!rd_en && !wr_en)); // R2

    AST_STORE_LOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        hsb_pull_low |-> (!rd_en && !wr_en)); // R4

    AST_STORE_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |=> !hsb_pull_low); // R4

    AST_NEW_WRITE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_req_n && wr_en) |-> $past(wr_en)); // R5

    AST_RECALL_LOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        array_recall |-> (!rd_en && !wr_en)); // R7

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hsb_pull_low && array_recall)); // R10

    AST_STORE_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |=> !store_done); // R11

    AST_RECALL_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_done |=> !recall_done); // R11

endmodule

bind nvs_seq_ctrl nvs_seq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_ok       (pwr_ok),
    .hw_req_n     (hw_req_n),
    .hsb_pull_low (hsb_pull_low),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .array_recall (array_recall),
    .store_done   (store_done),
    .recall_done  (recall_done)
);

// File: tb/nvs_seq_ctrl_bench.sv
`timescale 1ns/1ps
module nvs_seq_ctrl_bench;

    localparam int ST = 12;
    localparam int PU = 16;
    localparam int SW = 6;
    localparam int GR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b0, hw_req_n = 1'b1;
    logic sw_store = 1'b0, sw_recall = 1'b0, auto_off = 1'b0, auto_on = 1'b0;
    logic rd_req = 1'b0, wr_req = 1'b0;
    logic hsb_pull_low, rd_en, wr_en, array_store, array_recall, store_done, recall_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nvs_seq_ctrl #(
        .STORE_CYC(ST), .PU_RECALL_CYC(PU), .SW_RECALL_CYC(SW), .GRACE_CYC(GR)
    ) u_nvs_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .hw_req_n(hw_req_n),
        .hsb_pull_low(hsb_pull_low), .sw_store(sw_store), .sw_recall(sw_recall),
        .auto_off(auto_off), .auto_on(auto_on), .rd_req(rd_req), .wr_req(wr_req),
        .rd_en(rd_en), .wr_en(wr_en), .array_store(array_store),
        .array_recall(array_recall), .store_done(store_done), .recall_done(recall_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge. Samples 1 ns later each cycle until the selected
    // signal (0: busy, 1: recall) has been high and drops. Returns at a negedge.
    task automatic run_len(input int sel, output int len, output int dones, output int leaks);
        logic s;
        len = 0; dones = 0; leaks = 0;
        for (int i = 0; i < 1000; i++) begin
            #1;
            s = (sel == 0) ? hsb_pull_low : array_recall;
            dones += (sel == 0) ? int'(store_done) : int'(recall_done);
            if (s) begin
                len++;
                if (rd_en || wr_en) leaks++;
            end
            @(negedge clk);
            if (!s && len > 0) break;
        end
    endtask

    task automatic watch(input int n, output int busy_c, output int rec_c);
        busy_c = 0; rec_c = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            busy_c += int'(hsb_pull_low);
            rec_c  += int'(array_recall);
            @(negedge clk);
        end
    endtask

    task automatic one_write();
        @(negedge clk); wr_req = 1'b1;
        @(negedge clk); wr_req = 1'b0;
    endtask

    task automatic t_reset_powerup();
        int len, dn, lk, b, r;
        rd_req = 1'b1; wr_req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 busy in reset", hsb_pull_low, 0);
        check("R1 recall in reset", array_recall, 0);
        check("R2 rd_en in reset", rd_en, 0);
        check("R2 wr_en in reset", wr_en, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        watch(4, b, r);
        check("R1 no recall without supply", r, 0);
        rd_req = 1'b0; wr_req = 1'b0;
        pwr_ok = 1'b1;
        @(negedge clk);
        run_len(1, len, dn, lk);
        check("R1 power-up recall length", len, PU);
        check("R11 power-up recall done pulses", dn, 1);
        rd_req = 1'b1; #1;
        check("R2 read enabled in idle", rd_en, 1);
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic t_clean_hw();
        int b, r;
        hw_req_n = 1'b0;
        @(negedge clk);
        watch(GR + ST + 4, b, r);
        check("R3 clean hardware request gives no store", b, 0);
        hw_req_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_dirty_hw();
        int len, dn, lk;
        wr_req = 1'b1; #1;
        check("R2 write enabled in idle", wr_en, 1);
        @(negedge clk); hw_req_n = 1'b0; #1;
        check("R5 write in progress continues", wr_en, 1);
        @(negedge clk); wr_req = 1'b0; rd_req = 1'b1; #1;
        check("R5 read during grace", rd_en, 1);
        @(negedge clk); rd_req = 1'b0; wr_req = 1'b1; #1;
        check("R5 new write refused", wr_en, 0);
        @(negedge clk); wr_req = 1'b0; #1;
        check("R4 no busy in grace cycle 3", hsb_pull_low, 0);
        @(negedge clk); #1;
        check("R4 no busy in grace cycle 4", hsb_pull_low, 0);
        @(negedge clk);
        run_len(0, len, dn, lk);
        check("R4 store length after grace", len, ST);
        check("R11 store done pulses", dn, 1);
        wr_req = 1'b1; #1;
        check("R5 write refused while request low", wr_en, 0);
        @(negedge clk); hw_req_n = 1'b1; #1;
        check("R5 write allowed after release", wr_en, 1);
        @(negedge clk); wr_req = 1'b0;
    endtask

    task automatic t_sw_recall();
        int len, dn, lk, b, r;
        sw_recall = 1'b1;
        @(negedge clk); sw_recall = 1'b0; rd_req = 1'b1;
        run_len(1, len, dn, lk);
        check("R7 software recall length", len, SW);
        check("R7 reads blocked in recall", lk, 0);
        check("R11 software recall done pulses", dn, 1);
        rd_req = 1'b0;
        hw_req_n = 1'b0;
        @(negedge clk);
        watch(GR + ST + 4, b, r);
        check("R12 recall cleared dirty", b, 0);
        hw_req_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_sw_store();
        int len, dn, lk, b, r;
        sw_store = 1'b1;
        @(negedge clk); sw_store = 1'b0; hw_req_n = 1'b0;
        run_len(0, len, dn, lk);
        check("R6 clean software store length", len, ST);
        watch(GR + ST + 4, b, r);
        check("R10 request during store ignored (busy)", b, 0);
        check("R10 request during store ignored (recall)", r, 0);
        hw_req_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_power_fail();
        int len, dn, lk, b, r;
        one_write();
        @(negedge clk); pwr_ok = 1'b0; rd_req = 1'b1; #1;
        check("R2 read blocked on supply loss", rd_en, 0);
        @(negedge clk);
        run_len(0, len, dn, lk);
        check("R8 power-fail store length", len, ST);
        watch(5, b, r);
        check("R8 no recall while supply low", r, 0);
        rd_req = 1'b0; pwr_ok = 1'b1;
        @(negedge clk);
        run_len(1, len, dn, lk);
        check("R8 recall after supply returns", len, PU);
    endtask

    task automatic t_auto_toggle();
        int len, dn, lk, b, r;
        auto_off = 1'b1;
        @(negedge clk); auto_off = 1'b0;
        one_write();
        @(negedge clk); pwr_ok = 1'b0;
        @(negedge clk);
        watch(ST + 6, b, r);
        check("R9 no store with automatic store off", b, 0);
        pwr_ok = 1'b1;
        @(negedge clk);
        run_len(1, len, dn, lk);
        check("R9 recall after disabled outage", len, PU);
        auto_on = 1'b1;
        @(negedge clk); auto_on = 1'b0;
        one_write();
        @(negedge clk); pwr_ok = 1'b0;
        @(negedge clk);
        run_len(0, len, dn, lk);
        check("R9 store again after automatic store on", len, ST);
        pwr_ok = 1'b1;
        @(negedge clk);
        run_len(1, len, dn, lk);
    endtask

    initial begin
        t_reset_powerup();
        t_clean_hw();
        t_dirty_hw();
        t_sw_recall();
        t_sw_store();
        t_power_fail();
        t_auto_toggle();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule